// File: doc/BRIEF.md
# Replication Factor Resampler

This block turns a set of per-particle importance weights into integer replication counts for the resampling step of a particle filter. Instead of dividing each weight by the total, it divides only once: the integer part of the total weight selects a reciprocal from a small constant table, and one multiplication by the particle count gives a common scale factor D. Each particle's count is then its weight times D, truncated toward zero. The random offset of residual systematic resampling is fixed at zero, so the block needs no random source.

A pass starts with a one-cycle `start_i` pulse. At that pulse the block takes in the total weight and the index of the heaviest particle. It then walks the weight register file in index order. It reads one weight per cycle through a combinational read port and writes one count per cycle into the count register file. Truncation usually leaves the counts summing to N below M. One extra write therefore adds M − N to the heaviest particle's count, so that the counts sum to exactly M. A pass produces M + 1 writes, and `done_o` marks the last of them.

Weights are unsigned fixed point with `WGT_FRAC` fraction bits (Q1.7 by default, so 1.0 is 128). The total is unsigned with the same number of fraction bits.

Top module: `rsr_engine`

## Requirements
- R1: While `rst_n` is low, and from reset until the first accepted start, `rf_we_o` and `done_o` are low.
- R2: The reciprocal table index is k = the integer part of `wsum_i` (`wsum_i >> WGT_FRAC`), clamped to 1..M. A total of 0 uses k = 1, and a total above M uses k = M.
- R3: The count for particle m is min(floor(w_m · D_raw / 2^(WGT_FRAC+RECIP_FRAC)), M), where D_raw = M · floor(2^RECIP_FRAC / k) and RECIP_FRAC = 16 by default.
- R4: After `start_i` is sampled high at a clock edge, the first count appears at the outputs after the next edge. The M counts are written on consecutive cycles to addresses 0, 1, …, M−1.
- R5: In the cycle after address M−1, the block writes to the heavy index the value c_h + max(M − N, 0). Here c_h is that particle's count from the same pass and N is the sum of all M counts.
- R6: `done_o` is high for exactly one cycle, together with the correction write. A pass shows `rf_we_o` high for exactly M + 1 consecutive cycles.
- R7: `start_i` is ignored while a pass is running. `wsum_i` and `heavy_idx_i` are captured only when a start is accepted, so changing them later has no effect on the pass.
- R8: During the M count cycles, `wt_addr_o` gives the index of the particle whose weight is being used. The weight for that address must be present on `weight_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a pass when the block is idle |
| wsum_i | input | SUM_W (14) | Total weight, fixed point with WGT_FRAC fraction bits |
| heavy_idx_i | input | IDX_W (6) | Index of the particle with the largest weight |
| wt_addr_o | output | IDX_W (6) | Read address into the weight register file |
| weight_i | input | WGT_W (8) | Weight read back for `wt_addr_o` (combinational) |
| rf_we_o | output | 1 | Write enable for the count register file |
| rf_addr_o | output | IDX_W (6) | Write address for the count register file |
| rf_data_o | output | CNT_W (7) | Replication count to write |
| done_o | output | 1 | Pass complete; high with the correction write |

## Verification
The bench uses the default build: M = 64, 8-bit weights with 7 fraction bits, and a 16-bit reciprocal. These are the only values at which all 64 table entries, both ends of the index clamp (a zero total and a total of 127.99) and the count clamp at M are exercised in a full-length pass. A behavioural model predicts every write of a pass from the requirements and checks the outputs cycle by cycle. The stimuli cover uniform weights whose counts sum to exactly M, all-zero weights where the whole shortfall goes to one particle, counts whose sum exceeds M, and a start pulse delivered in the middle of a pass.

// File: rtl/rsr_pkg.sv
package rsr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } rsr_state_e;

  // floor(2^frac / k), used to build the reciprocal table at elaboration
  function automatic int unsigned recip_val(input int unsigned k, input int unsigned frac);
    return (32'd1 << frac) / k;
  endfunction

endpackage

// File: rtl/rsr_recip_lut.sv
module rsr_recip_lut #(
  parameter int NUM_PART   = 64,
  parameter int SUM_W      = 14,
  parameter int WGT_FRAC   = 7,
  parameter int RECIP_FRAC = 16,
  parameter int RECIP_W    = RECIP_FRAC + 1,
  parameter int IDX_W      = $clog2(NUM_PART)
) (
  input  logic [SUM_W-1:0]   wsum_i,
  output logic [RECIP_W-1:0] recip_o
);

  localparam int INT_W = SUM_W - WGT_FRAC;

  logic [INT_W-1:0]   int_part;
  logic [IDX_W-1:0]   sel;
  logic [RECIP_W-1:0] tbl [NUM_PART];

  assign int_part = wsum_i[SUM_W-1:WGT_FRAC];

  // Clamp the whole-number part of the total to 1..NUM_PART
  always_comb begin
    if (int_part == '0) begin
      sel = '0;
    end else if ({1'b0, int_part} > (INT_W+1)'(NUM_PART)) begin
      sel = IDX_W'(NUM_PART - 1);
    end else begin
      sel = IDX_W'(int_part - INT_W'(1));
    end
  end

  for (genvar g = 0; g < NUM_PART; g++) begin : g_entry
    assign tbl[g] = RECIP_W'(rsr_pkg::recip_val(g + 1, RECIP_FRAC));
  end

  assign recip_o = tbl[sel];

endmodule

// File: rtl/rsr_scale.sv
module rsr_scale #(
  parameter int NUM_PART   = 64,
  parameter int WGT_W      = 8,
  parameter int WGT_FRAC   = 7,
  parameter int RECIP_FRAC = 16,
  parameter int D_W        = 23,
  parameter int CNT_W      = 7
) (
  input  logic [WGT_W-1:0] weight_i,
  input  logic [D_W-1:0]   dscale_i,
  output logic [CNT_W-1:0] factor_o
);

  localparam int PROD_W = WGT_W + D_W;
  localparam int SHIFT  = WGT_FRAC + RECIP_FRAC;

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] whole;

  assign prod  = PROD_W'(weight_i) * PROD_W'(dscale_i);
  assign whole = prod >> SHIFT;

  always_comb begin
    if (whole > PROD_W'(NUM_PART)) begin
      factor_o = CNT_W'(NUM_PART);
    end else begin
      factor_o = CNT_W'(whole);
    end
  end

endmodule

// File: rtl/rsr_ctrl.sv
module rsr_ctrl #(
  parameter int NUM_PART = 64,
  parameter int IDX_W    = $clog2(NUM_PART)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  output rsr_pkg::rsr_state_e     state_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic                    accept_o
);

  import rsr_pkg::*;

  rsr_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;
  logic             last_idx;

  assign last_idx = (idx_q == IDX_W'(NUM_PART - 1));
  assign accept_o = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_RUN;
          idx_d   = '0;
          idx_en  = 1'b1;
        end
      end
      ST_RUN: begin
        idx_en = 1'b1;
        idx_d  = idx_q + IDX_W'(1);
        if (last_idx) begin
          state_d = ST_FIX;
        end
      end
      ST_FIX: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;

endmodule

// File: rtl/rsr_accum.sv
module rsr_accum #(
  parameter int NUM_PART = 64,
  parameter int CNT_W    = 7,
  parameter int IDX_W    = $clog2(NUM_PART)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             acc_en_i,
  input  logic             is_heavy_i,
  input  logic [CNT_W-1:0] factor_i,
  output logic [CNT_W-1:0] shortfall_o,
  output logic [CNT_W-1:0] heavy_cnt_o
);

  localparam int SUMR_W = CNT_W + IDX_W;

  logic [SUMR_W-1:0] sum_q, sum_d;
  logic              sum_en;
  logic [CNT_W-1:0]  heavy_q, heavy_d;
  logic              heavy_en;

  always_comb begin
    sum_en   = clr_i | acc_en_i;
    sum_d    = clr_i ? '0 : sum_q + SUMR_W'(factor_i);
    heavy_en = clr_i | (acc_en_i & is_heavy_i);
    heavy_d  = clr_i ? '0 : factor_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (sum_en) begin
      sum_q <= sum_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      heavy_q <= '0;
    end else if (heavy_en) begin
      heavy_q <= heavy_d;
    end
  end

  // Missing count is M - N, or nothing when truncation already reached M
  assign shortfall_o = (sum_q < SUMR_W'(NUM_PART)) ? CNT_W'(SUMR_W'(NUM_PART) - sum_q) : '0;
  assign heavy_cnt_o = heavy_q;

endmodule

// File: rtl/rsr_engine.sv
module rsr_engine #(
  parameter int NUM_PART   = 64,
  parameter int WGT_W      = 8,
  parameter int WGT_FRAC   = 7,
  parameter int RECIP_FRAC = 16,
  parameter int IDX_W      = $clog2(NUM_PART),
  parameter int CNT_W      = IDX_W + 1,
  parameter int SUM_W      = WGT_W + IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [SUM_W-1:0] wsum_i,
  input  logic [IDX_W-1:0] heavy_idx_i,
  output logic [IDX_W-1:0] wt_addr_o,
  input  logic [WGT_W-1:0] weight_i,
  output logic             rf_we_o,
  output logic [IDX_W-1:0] rf_addr_o,
  output logic [CNT_W-1:0] rf_data_o,
  output logic             done_o
);

  import rsr_pkg::*;

  localparam int RECIP_W = RECIP_FRAC + 1;
  localparam int D_W     = RECIP_W + IDX_W;
  localparam int MUL_W   = RECIP_W + CNT_W;

  rsr_state_e       state;
  logic [IDX_W-1:0] idx;
  logic             accept;
  logic [RECIP_W-1:0] recip;
  logic [MUL_W-1:0] d_full;
  logic [D_W-1:0]   d_q;
  logic [IDX_W-1:0] heavy_q;
  logic [CNT_W-1:0] factor;
  logic [CNT_W-1:0] shortfall;
  logic [CNT_W-1:0] heavy_cnt;

  logic             we_d, we_q;
  logic [IDX_W-1:0] addr_d, addr_q;
  logic [CNT_W-1:0] data_d, data_q;
  logic             done_d, done_q;

  rsr_ctrl #(
    .NUM_PART (NUM_PART),
    .IDX_W    (IDX_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .state_o  (state),
    .idx_o    (idx),
    .accept_o (accept)
  );

  rsr_recip_lut #(
    .NUM_PART   (NUM_PART),
    .SUM_W      (SUM_W),
    .WGT_FRAC   (WGT_FRAC),
    .RECIP_FRAC (RECIP_FRAC),
    .RECIP_W    (RECIP_W),
    .IDX_W      (IDX_W)
  ) u_lut (
    .wsum_i  (wsum_i),
    .recip_o (recip)
  );

  // The single multiplier of the pass: D = M * (1/W)
  assign d_full = MUL_W'(recip) * MUL_W'(NUM_PART);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q     <= '0;
      heavy_q <= '0;
    end else if (accept) begin
      d_q     <= D_W'(d_full);
      heavy_q <= heavy_idx_i;
    end
  end

  rsr_scale #(
    .NUM_PART   (NUM_PART),
    .WGT_W      (WGT_W),
    .WGT_FRAC   (WGT_FRAC),
    .RECIP_FRAC (RECIP_FRAC),
    .D_W        (D_W),
    .CNT_W      (CNT_W)
  ) u_scale (
    .weight_i (weight_i),
    .dscale_i (d_q),
    .factor_o (factor)
  );

  rsr_accum #(
    .NUM_PART (NUM_PART),
    .CNT_W    (CNT_W),
    .IDX_W    (IDX_W)
  ) u_accum (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (accept),
    .acc_en_i    (state == ST_RUN),
    .is_heavy_i  (idx == heavy_q),
    .factor_i    (factor),
    .shortfall_o (shortfall),
    .heavy_cnt_o (heavy_cnt)
  );

  always_comb begin
    we_d   = 1'b0;
    addr_d = '0;
    data_d = '0;
    done_d = 1'b0;
    case (state)
      ST_RUN: begin
        we_d   = 1'b1;
        addr_d = idx;
        data_d = factor;
      end
      ST_FIX: begin
        we_d   = 1'b1;
        addr_d = heavy_q;
        data_d = heavy_cnt + shortfall;
        done_d = 1'b1;
      end
      default: begin
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      we_q   <= we_d;
      addr_q <= addr_d;
      data_q <= data_d;
      done_q <= done_d;
    end
  end

  assign wt_addr_o = idx;
  assign rf_we_o   = we_q;
  assign rf_addr_o = addr_q;
  assign rf_data_o = data_q;
  assign done_o    = done_q;

endmodule

// File: rtl/rsr_engine_chk.sv
module rsr_engine_chk #(
  parameter int NUM_PART = 64,
  parameter int IDX_W    = 6,
  parameter int CNT_W    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             rf_we_o,
  input logic [IDX_W-1:0] rf_addr_o,
  input logic [CNT_W-1:0] rf_data_o,
  input logic             done_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!rf_we_o && !done_o)
        else $error("write or done during reset");
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (rf_data_o <= CNT_W'(NUM_PART)));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_o && $past(rf_we_o) && !done_o) |-> (rf_addr_o == $past(rf_addr_o) + IDX_W'(1)));

  assert_done_has_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (rf_we_o && $past(rf_we_o)));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_pass_follows_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_o && !$past(rf_we_o)) |-> $past(start_i, 2));

endmodule

bind rsr_engine rsr_engine_chk #(
  .NUM_PART (NUM_PART),
  .IDX_W    (IDX_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .rf_we_o   (rf_we_o),
  .rf_addr_o (rf_addr_o),
  .rf_data_o (rf_data_o),
  .done_o    (done_o)
);

// File: tb/rsr_engine_test.sv
`timescale 1ns/1ps
module rsr_engine_test;

  localparam int M = 64;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [13:0] wsum_i;
  logic [5:0]  heavy_idx_i;
  logic [5:0]  wt_addr_o;
  logic [7:0]  weight_i;
  logic        rf_we_o;
  logic [5:0]  rf_addr_o;
  logic [6:0]  rf_data_o;
  logic        done_o;

  logic [7:0] wmem [M];
  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 0;

  int exp_addr [M+1];
  int exp_data [M+1];

  rsr_engine uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .wsum_i      (wsum_i),
    .heavy_idx_i (heavy_idx_i),
    .wt_addr_o   (wt_addr_o),
    .weight_i    (weight_i),
    .rf_we_o     (rf_we_o),
    .rf_addr_o   (rf_addr_o),
    .rf_data_o   (rf_data_o),
    .done_o      (done_o)
  );

  assign weight_i = wmem[wt_addr_o];

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      mismatched++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cycles);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, expv, $time);
    end
  endtask

  // Reference model built from R2, R3, R5
  task automatic build_expect(input int wsum, input int heavy);
    int k;
    longint dr;
    int sum;
    int r [M];
    k = wsum / 128;
    if (k < 1) k = 1;
    if (k > M) k = M;
    dr = longint'(M) * ((longint'(1) << 16) / k);
    sum = 0;
    for (int m = 0; m < M; m++) begin
      longint p;
      p = (longint'(wmem[m]) * dr) >>> 23;
      r[m] = (p > M) ? M : int'(p);
      sum += r[m];
      exp_addr[m] = m;
      exp_data[m] = r[m];
    end
    exp_addr[M] = heavy;
    exp_data[M] = r[heavy] + ((sum < M) ? (M - sum) : 0);
  endtask

  task automatic run_pass(input int wsum, input int heavy, input bit poke, input string tag);
    build_expect(wsum, heavy);
    @(negedge clk);
    wsum_i = 14'(wsum);
    heavy_idx_i = 6'(heavy);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R7: later changes to the totals must not matter
    wsum_i = 14'(wsum ^ 14'h2A55);
    heavy_idx_i = 6'(heavy ^ 6'h15);
    check(rf_we_o == 1'b0, {"R4 no write in start cycle ", tag}, int'(rf_we_o), 0);
    for (int j = 0; j <= M; j++) begin
      @(negedge clk);
      if (poke && j == 9) start_i = 1'b1;
      if (poke && j == 10) start_i = 1'b0;
      if (j < M) begin
        check(wt_addr_o == 6'((j + 1) % M) || j == M - 1, {"R8 read address ", tag}, int'(wt_addr_o), (j + 1) % M);
      end
      check(rf_we_o == 1'b1, {"R6 write enable ", tag}, int'(rf_we_o), 1);
      check(int'(rf_addr_o) == exp_addr[j], (j == M) ? {"R5 fix address ", tag} : {"R4 address ", tag},
            int'(rf_addr_o), exp_addr[j]);
      check(int'(rf_data_o) == exp_data[j], (j == M) ? {"R5 fix count ", tag} : {"R3 count ", tag},
            int'(rf_data_o), exp_data[j]);
      check(done_o == (j == M), {"R6 done timing ", tag}, int'(done_o), int'(j == M));
    end
    @(negedge clk);
    check(rf_we_o == 1'b0, {"R6 write ends ", tag}, int'(rf_we_o), 0);
    check(done_o == 1'b0, {"R6 done ends ", tag}, int'(done_o), 0);
    // R7: a start poked mid-pass must not launch a second pass
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      check(rf_we_o == 1'b0, {"R7 no extra pass ", tag}, int'(rf_we_o), 0);
    end
  endtask

  initial begin
    int tot;
    int best;
    rst_n = 1'b0;
    start_i = 1'b0;
    wsum_i = '0;
    heavy_idx_i = '0;
    for (int m = 0; m < M; m++) wmem[m] = 8'd0;
    repeat (3) @(negedge clk);
    check(rf_we_o == 1'b0, "R1 reset write", int'(rf_we_o), 0);
    check(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(rf_we_o == 1'b0 && done_o == 1'b0, "R1 idle after reset", int'(rf_we_o), 0);

    // Uniform weights of 1.0, total 64.0: every count 1, no shortfall
    for (int m = 0; m < M; m++) wmem[m] = 8'd128;
    run_pass(64 * 128, 5, 1'b0, "uniform");

    // Zero weights and zero total: k clamps to 1, whole M goes to the heavy index
    for (int m = 0; m < M; m++) wmem[m] = 8'd0;
    run_pass(0, 63, 1'b0, "R2 zero total");

    // Mixed weights with their true total
    tot = 0;
    best = 0;
    for (int m = 0; m < M; m++) begin
      wmem[m] = 8'((m * 37) % 129);
      tot += int'(wmem[m]);
      if (wmem[m] > wmem[best]) best = m;
    end
    run_pass(tot, best, 1'b0, "mixed");

    // Total above M clamps the table index to M
    for (int m = 0; m < M; m++) wmem[m] = 8'd255;
    run_pass(16383, 0, 1'b0, "R2 large total");

    // Zero total with heavy weights: each count clamps at M, sum exceeds M
    run_pass(0, 17, 1'b0, "R3 count clamp");

    // Single particle carries all weight; start poked mid-pass
    for (int m = 0; m < M; m++) wmem[m] = 8'd0;
    wmem[0] = 8'd128;
    run_pass(128, 0, 1'b1, "R7 single heavy");

    finished = 1;
    summary();
  end

endmodule